// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the results of instructions that have been issued but not yet retired, so that they retire strictly in program order even though their results arrive in any order. Each issued instruction takes the next free slot at the tail of a circular store. The slot number comes back to the issuer and serves as the tag of the result. Execution units later return a result against that tag, together with an exception flag and a branch-mispredict flag. The oldest slot retires once its result is present. Retirement writes the register file for a register-writing instruction, emits store data for a store, and writes nothing for a branch that was predicted correctly.

A rename table maps each architectural register to the youngest slot that will produce it. A single lookup port reports whether a register is pending, which slot owns it, and, once that slot has its result, the value itself. This lets dependent instructions read results that are complete but not yet retired. An exception or a mispredicted branch at the oldest slot discards every entry and clears the rename table. An exception also raises a precise-exception strobe with the faulting PC.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `issueReady` is 1, `issueTag` is 0, `srcPending` is 0, and `regWrEn`, `storeEn`, `excRaise` and `flushOut` are all 0.
- R2: `issueTag` shows the slot the next issue will take. Successive issues take consecutive slots, wrapping from DEPTH-1 to 0.
- R3: With DEPTH entries outstanding, `issueReady` is 0 and an `issueValid` pulse changes nothing. A flush cycle also holds `issueReady` at 0.
- R4: A writeback marks only the slot named by `wbTag`. A younger slot that completes first does not retire before the oldest slot completes.
- R5: Kind encoding: 0 writes a register, 1 is a store, 2 is a branch. When the oldest slot has its result and no flag is set, it retires in that cycle. Kind 0 asserts `regWrEn` with `commitDest`/`commitData`. Kind 1 asserts `storeEn` with the value on `commitData` and no register write.
- R6: After a kind-0 issue, a lookup of its destination reports pending with the slot as `srcTag`. A younger writer of the same register takes over the mapping. Once the mapped slot has its result, `srcReady` is 1 and `srcValue` holds that result.
- R7: Retiring a slot clears its register's mapping only if the mapping still names that slot.
- R8: When the oldest slot carries an exception flag, `excRaise` and `flushOut` assert and `headPc` shows that slot's PC. There is no register write. After that edge the buffer is empty and no register is pending.
- R9: When the oldest slot is a branch with the mispredict flag set, `flushOut` asserts without `excRaise` or any write, and all entries are discarded. A branch without the flag retires silently and the next slot retires normally.
- R10: An issue and a retirement can happen in the same cycle. Both take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue request |
| issueKind | input | 2 | 0 register write, 1 store, 2 branch |
| issueDest | input | REGW | Destination register |
| issuePc | input | PCW | Instruction PC |
| issueReady | output | 1 | A slot is free and no flush is in progress |
| issueTag | output | TAGW | Slot the next issue takes |
| wbValid | input | 1 | Result broadcast valid |
| wbTag | input | TAGW | Slot of the result |
| wbValue | input | XLEN | Result value |
| wbExc | input | 1 | Result carries an exception |
| wbMispredict | input | 1 | Branch resolved as mispredicted |
| srcReg | input | REGW | Register to look up |
| srcPending | output | 1 | Register awaits an in-flight slot |
| srcTag | output | TAGW | Slot that produces the register |
| srcReady | output | 1 | That slot already has its result |
| srcValue | output | XLEN | Result held by that slot |
| regWrEn | output | 1 | Register file write strobe |
| storeEn | output | 1 | Store retire strobe |
| commitDest | output | REGW | Register written at retirement |
| commitData | output | XLEN | Value retired |
| excRaise | output | 1 | Precise exception at oldest slot |
| flushOut | output | 1 | All entries discarded at this edge |
| headPc | output | PCW | PC of the oldest slot |

## Verification
The bench builds the block with DEPTH=4, NREG=8, XLEN=16 and PCW=16. With a four-slot store the full condition, the pointer wrap and the wrap-bit full/empty distinction all come up within a few dozen cycles. The same tests also reach a retirement and an issue in the same cycle while three entries are in flight. The eight-register table is still large enough for two writers of one register to race the rename mapping.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } robKind_e;

  typedef struct packed {
    logic doIssue;
    logic doCommit;
    logic doFlush;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAGW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic            headDone,
  input  logic            headExc,
  input  logic            headMisp,
  input  logic [1:0]      headKind,
  output robStrobe_t      strobe,
  output logic [TAGW-1:0] allocTag,
  output logic [TAGW-1:0] headTag,
  output logic            issueReady,
  output logic            regWrEn,
  output logic            storeEn,
  output logic            excRaise,
  output logic            flushOut
);
  logic [TAGW:0] headPtr, tailPtr;
  logic empty, full, retireOk, flushNow;

  assign empty    = (headPtr == tailPtr);
  assign full     = (headPtr[TAGW] != tailPtr[TAGW]) &&
                    (headPtr[TAGW-1:0] == tailPtr[TAGW-1:0]);
  assign retireOk = !empty && headDone;
  assign flushNow = retireOk &&
                    (headExc || (headKind == KIND_BRANCH && headMisp));

  assign strobe.doFlush  = flushNow;
  assign strobe.doCommit = retireOk && !flushNow;
  assign strobe.doIssue  = issueValid && !full && !flushNow;

  assign allocTag   = tailPtr[TAGW-1:0];
  assign headTag    = headPtr[TAGW-1:0];
  assign issueReady = !full && !flushNow;
  assign regWrEn    = strobe.doCommit && (headKind == KIND_ALU);
  assign storeEn    = strobe.doCommit && (headKind == KIND_STORE);
  assign excRaise   = retireOk && headExc;
  assign flushOut   = flushNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobe.doFlush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.doCommit) headPtr <= headPtr + 1'b1;
      if (strobe.doIssue)  tailPtr <= tailPtr + 1'b1;
    end
  end
endmodule

// File: rtl/rob_dpath.sv
module rob_dpath
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  localparam int TAGW = $clog2(DEPTH),
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  robStrobe_t      strobe,
  input  logic [TAGW-1:0] allocTag,
  input  logic [TAGW-1:0] headTag,
  input  logic [1:0]      issueKind,
  input  logic [REGW-1:0] issueDest,
  input  logic [PCW-1:0]  issuePc,
  input  logic            wbValid,
  input  logic [TAGW-1:0] wbTag,
  input  logic [XLEN-1:0] wbValue,
  input  logic            wbExc,
  input  logic            wbMispredict,
  input  logic [REGW-1:0] srcReg,
  output logic            srcPending,
  output logic [TAGW-1:0] srcTag,
  output logic            srcReady,
  output logic [XLEN-1:0] srcValue,
  output logic            headDone,
  output logic            headExc,
  output logic            headMisp,
  output logic [1:0]      headKind,
  output logic [REGW-1:0] commitDest,
  output logic [XLEN-1:0] commitData,
  output logic [PCW-1:0]  headPc
);
  logic            entValid [DEPTH];
  logic            entDone  [DEPTH];
  logic            entExc   [DEPTH];
  logic            entMisp  [DEPTH];
  logic [1:0]      entKind  [DEPTH];
  logic [REGW-1:0] entDest  [DEPTH];
  logic [PCW-1:0]  entPc    [DEPTH];
  logic [XLEN-1:0] entValue [DEPTH];
  logic            regBusy  [NREG];
  logic [TAGW-1:0] regMap   [NREG];

  // Slot flags: flush wins, then issue overrides a stale writeback.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
        entExc[i]   <= 1'b0;
        entMisp[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.doFlush) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end else begin
          if (strobe.doCommit && headTag == TAGW'(i)) entValid[i] <= 1'b0;
          if (wbValid && wbTag == TAGW'(i) && entValid[i]) begin
            entDone[i] <= 1'b1;
            entExc[i]  <= wbExc;
            entMisp[i] <= wbMispredict;
          end
          if (strobe.doIssue && allocTag == TAGW'(i)) begin
            entValid[i] <= 1'b1;
            entDone[i]  <= 1'b0;
            entExc[i]   <= 1'b0;
            entMisp[i]  <= 1'b0;
          end
        end
      end
    end
  end

  // Slot payload carries no reset; flags gate every use.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.doIssue && allocTag == TAGW'(i)) begin
        entKind[i] <= issueKind;
        entDest[i] <= issueDest;
        entPc[i]   <= issuePc;
      end
      if (wbValid && wbTag == TAGW'(i) && entValid[i]) entValue[i] <= wbValue;
    end
  end

  // Rename table: a same-cycle issue to the retiring register wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) begin
        regBusy[r] <= 1'b0;
        regMap[r]  <= '0;
      end
    end else if (strobe.doFlush) begin
      for (int r = 0; r < NREG; r++) regBusy[r] <= 1'b0;
    end else begin
      if (strobe.doCommit && headKind == KIND_ALU &&
          regBusy[commitDest] && regMap[commitDest] == headTag)
        regBusy[commitDest] <= 1'b0;
      if (strobe.doIssue && issueKind == KIND_ALU) begin
        regBusy[issueDest] <= 1'b1;
        regMap[issueDest]  <= allocTag;
      end
    end
  end

  assign headDone   = entValid[headTag] && entDone[headTag];
  assign headExc    = entExc[headTag];
  assign headMisp   = entMisp[headTag];
  assign headKind   = entKind[headTag];
  assign commitDest = entDest[headTag];
  assign commitData = entValue[headTag];
  assign headPc     = entPc[headTag];

  assign srcPending = regBusy[srcReg];
  assign srcTag     = regMap[srcReg];
  assign srcReady   = regBusy[srcReg] && entDone[regMap[srcReg]];
  assign srcValue   = entValue[regMap[srcReg]];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  localparam int TAGW = $clog2(DEPTH),
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [1:0]      issueKind,
  input  logic [REGW-1:0] issueDest,
  input  logic [PCW-1:0]  issuePc,
  output logic            issueReady,
  output logic [TAGW-1:0] issueTag,
  input  logic            wbValid,
  input  logic [TAGW-1:0] wbTag,
  input  logic [XLEN-1:0] wbValue,
  input  logic            wbExc,
  input  logic            wbMispredict,
  input  logic [REGW-1:0] srcReg,
  output logic            srcPending,
  output logic [TAGW-1:0] srcTag,
  output logic            srcReady,
  output logic [XLEN-1:0] srcValue,
  output logic            regWrEn,
  output logic            storeEn,
  output logic [REGW-1:0] commitDest,
  output logic [XLEN-1:0] commitData,
  output logic            excRaise,
  output logic            flushOut,
  output logic [PCW-1:0]  headPc
);
  robStrobe_t      strobe;
  logic [TAGW-1:0] headTag;
  logic            headDone, headExc, headMisp;
  logic [1:0]      headKind;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk, .rstN, .issueValid,
    .headDone, .headExc, .headMisp, .headKind,
    .strobe, .allocTag(issueTag), .headTag,
    .issueReady, .regWrEn, .storeEn, .excRaise, .flushOut
  );

  rob_dpath #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .PCW(PCW)) dpath (
    .clk, .rstN, .strobe, .allocTag(issueTag), .headTag,
    .issueKind, .issueDest, .issuePc,
    .wbValid, .wbTag, .wbValue, .wbExc, .wbMispredict,
    .srcReg, .srcPending, .srcTag, .srcReady, .srcValue,
    .headDone, .headExc, .headMisp, .headKind,
    .commitDest, .commitData, .headPc
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int TAGW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            issueValid,
  input logic            issueReady,
  input logic [TAGW-1:0] issueTag,
  input logic            regWrEn,
  input logic            storeEn,
  input logic            excRaise,
  input logic            flushOut
);
  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> issueTag == TAGW'($past(issueTag) + 1'b1));

  a_r3_hold_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (!issueReady && !flushOut) |=> $stable(issueTag));

  a_r5_one_retire_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, storeEn, excRaise}));

  a_r8_exc_flushes: assert property (@(posedge clk) disable iff (!rstN)
    excRaise |-> (flushOut && !regWrEn && !storeEn));

  a_r9_empty_after_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> (issueReady && issueTag == '0));
endmodule

bind rob_core rob_checker #(.TAGW(TAGW)) chk (
  .clk, .rstN, .issueValid, .issueReady, .issueTag,
  .regWrEn, .storeEn, .excRaise, .flushOut
);

// File: tb/rob_core_test.sv
module rob_core_test;
  localparam int DEPTH = 4, NREG = 8, XLEN = 16, PCW = 16;
  localparam int TAGW = $clog2(DEPTH), REGW = $clog2(NREG);

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueKind = '0;
  logic [REGW-1:0] issueDest = '0;
  logic [PCW-1:0] issuePc = '0;
  logic issueReady;
  logic [TAGW-1:0] issueTag;
  logic wbValid = 1'b0;
  logic [TAGW-1:0] wbTag = '0;
  logic [XLEN-1:0] wbValue = '0;
  logic wbExc = 1'b0, wbMispredict = 1'b0;
  logic [REGW-1:0] srcReg = '0;
  logic srcPending, srcReady;
  logic [TAGW-1:0] srcTag;
  logic [XLEN-1:0] srcValue;
  logic regWrEn, storeEn, excRaise, flushOut;
  logic [REGW-1:0] commitDest;
  logic [XLEN-1:0] commitData;
  logic [PCW-1:0] headPc;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .PCW(PCW)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issueOne(input int kind, input int dest, input int pc, output int tag);
    issueValid = 1'b1;
    issueKind = 2'(kind);
    issueDest = REGW'(dest);
    issuePc = PCW'(pc);
    #1 tag = int'(issueTag);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic wbOne(input int tag, input int val, input bit exc, input bit misp);
    wbValid = 1'b1;
    wbTag = TAGW'(tag);
    wbValue = XLEN'(val);
    wbExc = exc;
    wbMispredict = misp;
    @(negedge clk);
    wbValid = 1'b0;
    wbExc = 1'b0;
    wbMispredict = 1'b0;
  endtask

  task automatic look(input int r);
    srcReg = REGW'(r);
    #1;
  endtask

  task automatic testReset();
    chk("R1 issueReady", issueReady, 1);
    chk("R1 issueTag", issueTag, 0);
    look(3);
    chk("R1 srcPending", srcPending, 0);
    chk("R1 strobes", {regWrEn, storeEn, excRaise, flushOut}, 0);
  endtask

  task automatic testInOrder();
    int t0, t1;
    issueOne(0, 3, 'h100, t0);
    issueOne(0, 5, 'h104, t1);
    chk("R2 first tag", t0, 0);
    chk("R2 second tag", t1, 1);
    wbOne(1, 'hBBBB, 0, 0);
    chk("R4 younger done, no retire", regWrEn, 0);
    wbOne(0, 'hAAAA, 0, 0);
    chk("R5 retire wr", regWrEn, 1);
    chk("R5 retire dest", commitDest, 3);
    chk("R5 retire data", commitData, 'hAAAA);
    tick();
    chk("R5 second wr", regWrEn, 1);
    chk("R5 second dest", commitDest, 5);
    chk("R5 second data", commitData, 'hBBBB);
    tick();
    chk("R5 drained", regWrEn, 0);
  endtask

  task automatic testRename();
    int ta, tb;
    issueOne(0, 2, 'h200, ta);
    look(2);
    chk("R6 pending", srcPending, 1);
    chk("R6 tag", srcTag, ta);
    chk("R6 not ready", srcReady, 0);
    issueOne(0, 2, 'h204, tb);
    look(2);
    chk("R6 younger owns", srcTag, tb);
    wbOne(ta, 'h1111, 0, 0);
    chk("R5 older retires", regWrEn, 1);
    tick();
    look(2);
    chk("R7 mapping kept", srcPending, 1);
    chk("R7 mapping tag", srcTag, tb);
    wbOne(tb, 'h2222, 0, 0);
    look(2);
    chk("R6 ready", srcReady, 1);
    chk("R6 value", srcValue, 'h2222);
    tick();
    look(2);
    chk("R7 mapping cleared", srcPending, 0);
    chk("R2 wrap tag", issueTag, 0);
  endtask

  task automatic testFullAndConcurrent();
    int t, t4;
    issueOne(1, 0, 'h300, t);
    issueOne(0, 1, 'h304, t);
    issueOne(0, 4, 'h308, t);
    issueOne(0, 6, 'h30C, t);
    chk("R2 fourth tag", t, 3);
    chk("R3 full", issueReady, 0);
    issueOne(0, 5, 'h3F0, t);
    chk("R3 blocked tag", issueTag, 0);
    chk("R3 still full", issueReady, 0);
    look(5);
    chk("R3 blocked no rename", srcPending, 0);
    wbOne(0, 'h5555, 0, 0);
    chk("R5 store strobe", storeEn, 1);
    chk("R5 store no wr", regWrEn, 0);
    chk("R5 store data", commitData, 'h5555);
    wbOne(1, 'h0077, 0, 0);
    chk("R10 retire pending", regWrEn, 1);
    chk("R10 slot free", issueReady, 1);
    issueOne(0, 7, 'h310, t4);
    chk("R10 issued tag", t4, 0);
    chk("R10 tail moved", issueTag, 1);
    chk("R10 head moved", regWrEn, 0);
    look(7);
    chk("R10 rename", srcPending, 1);
  endtask

  task automatic testException();
    wbOne(3, 'h0033, 0, 0);
    chk("R4 head not done", regWrEn, 0);
    wbOne(2, 'h0099, 1, 0);
    chk("R8 exc", excRaise, 1);
    chk("R8 flush", flushOut, 1);
    chk("R8 no wr", regWrEn, 0);
    chk("R8 pc", headPc, 'h308);
    chk("R3 no issue during flush", issueReady, 0);
    tick();
    chk("R8 empty", issueReady, 1);
    chk("R8 tag reset", issueTag, 0);
    chk("R8 nothing left", {regWrEn, flushOut}, 0);
    look(6);
    chk("R8 r6 cleared", srcPending, 0);
    look(7);
    chk("R8 r7 cleared", srcPending, 0);
  endtask

  task automatic testBranches();
    int tb0, tb1;
    issueOne(2, 0, 'h400, tb0);
    issueOne(0, 1, 'h404, tb1);
    wbOne(tb1, 'h0044, 0, 0);
    wbOne(tb0, 0, 0, 1);
    chk("R9 flush", flushOut, 1);
    chk("R9 no exc", excRaise, 0);
    chk("R9 no wr", regWrEn, 0);
    tick();
    chk("R9 tag reset", issueTag, 0);
    chk("R9 younger gone", regWrEn, 0);
    look(1);
    chk("R9 r1 cleared", srcPending, 0);
    issueOne(2, 0, 'h500, tb0);
    issueOne(0, 3, 'h504, tb1);
    wbOne(tb0, 0, 0, 0);
    chk("R9 good branch silent", {regWrEn, storeEn, flushOut, excRaise}, 0);
    wbOne(tb1, 'h0abc, 0, 0);
    chk("R9 next retires", regWrEn, 1);
    chk("R9 next dest", commitDest, 3);
    chk("R9 next data", commitData, 'h0abc);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testInOrder();
    testRename();
    testFullAndConcurrent();
    testException();
    testBranches();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule